// File: doc/BRIEF.md
# Fetch Group Builder

This block forms the group of instruction words that goes to decode in one cycle. It takes an instruction cache line that is already held in a buffer, together with the current fetch PC. It then walks the line word by word, starting at the word the PC points to. The walk stops at the first of three limits: the fetch width, the last word of the line, or the first control instruction that the branch predictor calls taken. Each emitted slot carries the instruction word, its PC, its predicted next PC and a sequence number. The sequence numbers come from a running counter inside the block.

The block checks each word's major opcode against a configurable set of control opcodes. Only the slots that hold a control instruction raise a request to the external branch predictor. The predictor answers in the same cycle with a taken flag and a target for each slot. The block registers the whole group at the clock edge after the request.

The block also registers three values that the fetch loop uses. The first is the PC to fetch from next, which is the predicted next PC of the last emitted slot. The second is that PC plus four. The third is a running count of taken predictions. When the fault input is high, or when no request is made, the block emits an empty group and leaves all of its running state unchanged.

Top module: `fgb_builder`

## Requirements
- R1: After reset, no slot is valid and the group count is 0. The PC output equals the `RESET_PC` parameter and the next-PC output equals `RESET_PC`+4. The taken counter is 0, and the first emitted sequence number is 0.
- R2: When `go_i` is high and `fault_i` is low, the group appears on the outputs one clock edge later. Slot i holds line word (PC[5:2]+i) and has PC `pc_i`+4*i. Word k of the line sits in `line_i` bits [32k+31:32k], little-endian, so byte 4k is the least significant byte of that word.
- R3: The group never runs past the end of the line. With no taken prediction, the count is min(WIDTH, 16 − PC[5:2]) for a 64-byte line.
- R4: With no taken prediction and enough words left in the line, the group holds exactly WIDTH slots.
- R5: A word that is not a control instruction gets next PC = its PC + 4. It raises no predictor request, and the predictor's taken input for its slot is ignored.
- R6: A word is a control instruction when its opcode, bits [31:26], is in the `CTRL_OPC` set. By default that set is 0x1A and 0x30 to 0x3F. Each slot that would be emitted and holds a control instruction raises `pred_req_o[i]` in the request cycle, with `pred_pc_o[i]` = `pc_i`+4*i.
- R7: A control instruction that is predicted taken takes `pred_target_i[i]` as its next PC, and the group ends after that slot. A control instruction that is not taken gets next PC = PC + 4.
- R8: The emitted slots carry consecutive sequence numbers, and the numbering continues from one group to the next.
- R9: After a non-empty group, the PC output equals the last slot's next PC. The next-PC output always equals the PC output + 4.
- R10: When `fault_i` is high, or `go_i` is low, the group is empty. The sequence numbering, the PC outputs and the taken counter do not change.
- R11: The taken counter increases by one for each group that ends on a taken prediction.
- R12: The valid slots are always contiguous from slot 0, and the group count equals the number of valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Build a group from the buffered line this cycle |
| fault_i | input | 1 | The line is faulted; suppress the group |
| pc_i | input | ADDR_W | Current fetch PC |
| line_i | input | LINE_BYTES*8 | Buffered cache line, little-endian words |
| pred_req_o | output | WIDTH | Per-slot predictor request, control slots only |
| pred_pc_o | output | WIDTH*ADDR_W | Per-slot PC sent to the predictor |
| pred_taken_i | input | WIDTH | Per-slot taken decision from the predictor |
| pred_target_i | input | WIDTH*ADDR_W | Per-slot predicted target |
| grp_vld_o | output | WIDTH | Slot valid flags |
| grp_word_o | output | WIDTH*32 | Instruction word per slot |
| grp_pc_o | output | WIDTH*ADDR_W | PC per slot |
| grp_npc_o | output | WIDTH*ADDR_W | Predicted next PC per slot |
| grp_seq_o | output | WIDTH*SEQ_W | Sequence number per slot |
| grp_cnt_o | output | clog2(WIDTH+1) | Number of emitted slots this cycle |
| taken_cnt_o | output | CNT_W | Running count of taken predictions |
| pc_out_o | output | ADDR_W | PC for the next fetch |
| npc_out_o | output | ADDR_W | PC for the next fetch plus 4 |

## Verification
Suppose the internal sequence counter skips or repeats a value. The error shows up in the first slot of the very next non-empty group, one edge after the request, because that slot's sequence number no longer follows on from the previous group. Suppose the stop chain is wrong. Then a slot after a taken branch becomes valid, or the count no longer matches the line end, and this is visible in the group registered at the following edge. Suppose the held PC is corrupted. It shows at once on `pc_out_o`, and a suppressed cycle would change it where it must hold.

// File: rtl/fgb_pkg.sv
package fgb_pkg;
    localparam int INSN_BYTES = 4;
    localparam int INSN_BITS  = 32;
    localparam int OPC_HI     = 31;
    localparam int OPC_LO     = 26;
    localparam int OPC_W      = OPC_HI - OPC_LO + 1;
    // Bit n set means major opcode n is a control instruction.
    // Default: the jump group (0x1A) and all branch opcodes (0x30..0x3F).
    localparam logic [(1<<OPC_W)-1:0] CTRL_OPC_DEFAULT = 64'hFFFF_0000_0400_0000;
endpackage

// File: rtl/fgb_word_pick.sv
module fgb_word_pick
    import fgb_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int IDX_W      = 4
) (
    input  logic [LINE_BYTES*8-1:0] line_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [INSN_BITS-1:0]    word_o
);
    // Word k occupies bits [32k+31:32k]; byte 4k is its least significant byte.
    always_comb begin
        word_o = line_i[{idx_i, 5'd0} +: INSN_BITS];
    end
endmodule

// File: rtl/fgb_ctrl_dec.sv
module fgb_ctrl_dec
    import fgb_pkg::*;
#(
    parameter logic [(1<<OPC_W)-1:0] CTRL_OPC = CTRL_OPC_DEFAULT
) (
    input  logic [INSN_BITS-1:0] word_i,
    output logic                 is_ctrl_o
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc       = word_i[OPC_HI:OPC_LO];
        is_ctrl_o = CTRL_OPC[opc];
    end
endmodule

// File: rtl/fgb_builder.sv
module fgb_builder
    import fgb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int WIDTH      = 4,
    parameter int SEQ_W      = 16,
    parameter int CNT_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter logic [(1<<OPC_W)-1:0] CTRL_OPC = CTRL_OPC_DEFAULT,
    localparam int CW    = $clog2(WIDTH + 1),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int WORDS = LINE_BYTES / INSN_BYTES,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              go_i,
    input  logic                              fault_i,
    input  logic [ADDR_W-1:0]                 pc_i,
    input  logic [LINE_BYTES*8-1:0]           line_i,
    output logic [WIDTH-1:0]                  pred_req_o,
    output logic [WIDTH-1:0][ADDR_W-1:0]      pred_pc_o,
    input  logic [WIDTH-1:0]                  pred_taken_i,
    input  logic [WIDTH-1:0][ADDR_W-1:0]      pred_target_i,
    output logic [WIDTH-1:0]                  grp_vld_o,
    output logic [WIDTH-1:0][INSN_BITS-1:0]   grp_word_o,
    output logic [WIDTH-1:0][ADDR_W-1:0]      grp_pc_o,
    output logic [WIDTH-1:0][ADDR_W-1:0]      grp_npc_o,
    output logic [WIDTH-1:0][SEQ_W-1:0]       grp_seq_o,
    output logic [CW-1:0]                     grp_cnt_o,
    output logic [CNT_W-1:0]                  taken_cnt_o,
    output logic [ADDR_W-1:0]                 pc_out_o,
    output logic [ADDR_W-1:0]                 npc_out_o
);
    typedef struct packed {
        logic [WIDTH-1:0]                vld;
        logic [WIDTH-1:0][INSN_BITS-1:0] word;
        logic [WIDTH-1:0][ADDR_W-1:0]    pc;
        logic [WIDTH-1:0][ADDR_W-1:0]    npc;
        logic [WIDTH-1:0][SEQ_W-1:0]     seq;
        logic [CW-1:0]                   cnt;
        logic [SEQ_W-1:0]                seq_next;
        logic [CNT_W-1:0]                taken_cnt;
        logic [ADDR_W-1:0]               pc_out;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]     widx;
    logic [INSN_BITS-1:0] words   [WIDTH];
    logic                 is_ctrl [WIDTH];

    assign widx = pc_i[OFF_W-1:$clog2(INSN_BYTES)];

    // One extractor and one opcode decoder per slot.
    for (genvar g = 0; g < WIDTH; g++) begin : g_slot
        fgb_word_pick #(
            .LINE_BYTES (LINE_BYTES),
            .IDX_W      (IDX_W)
        ) u_pick (
            .line_i (line_i),
            .idx_i  (widx + IDX_W'(g)),
            .word_o (words[g])
        );

        fgb_ctrl_dec #(
            .CTRL_OPC (CTRL_OPC)
        ) u_dec (
            .word_i    (words[g]),
            .is_ctrl_o (is_ctrl[g])
        );
    end

    always_comb begin
        logic              halt;
        logic              took;
        logic [SEQ_W-1:0]  seq_run;
        logic [ADDR_W-1:0] last_npc;
        logic [ADDR_W-1:0] slot_pc;
        logic [ADDR_W-1:0] slot_npc;

        st_d      = st_q;
        st_d.vld  = '0;
        st_d.word = '0;
        st_d.pc   = '0;
        st_d.npc  = '0;
        st_d.seq  = '0;
        st_d.cnt  = '0;

        pred_req_o = '0;
        halt       = !go_i || fault_i;
        took       = 1'b0;
        seq_run    = st_q.seq_next;
        last_npc   = st_q.pc_out;

        for (int i = 0; i < WIDTH; i++) begin
            slot_pc      = pc_i + ADDR_W'(INSN_BYTES * i);
            pred_pc_o[i] = slot_pc;
            slot_npc     = slot_pc + ADDR_W'(INSN_BYTES);
            if (!halt && (int'(widx) + i < WORDS)) begin
                if (is_ctrl[i]) begin
                    pred_req_o[i] = 1'b1;
                    if (pred_taken_i[i]) begin
                        slot_npc = pred_target_i[i];
                        halt     = 1'b1;
                        took     = 1'b1;
                    end
                end
                st_d.vld[i]  = 1'b1;
                st_d.word[i] = words[i];
                st_d.pc[i]   = slot_pc;
                st_d.npc[i]  = slot_npc;
                st_d.seq[i]  = seq_run;
                seq_run      = seq_run + SEQ_W'(1);
                last_npc     = slot_npc;
                st_d.cnt     = st_d.cnt + CW'(1);
            end
        end

        st_d.seq_next = seq_run;
        st_d.pc_out   = last_npc;
        if (took) begin
            st_d.taken_cnt = st_q.taken_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pc_out <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_vld_o   = st_q.vld;
    assign grp_word_o  = st_q.word;
    assign grp_pc_o    = st_q.pc;
    assign grp_npc_o   = st_q.npc;
    assign grp_seq_o   = st_q.seq;
    assign grp_cnt_o   = st_q.cnt;
    assign taken_cnt_o = st_q.taken_cnt;
    assign pc_out_o    = st_q.pc_out;
    assign npc_out_o   = st_q.pc_out + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/fgb_checker.sv
module fgb_checker #(
    parameter int ADDR_W = 32,
    parameter int WIDTH  = 4,
    parameter int SEQ_W  = 16,
    parameter int CNT_W  = 16,
    parameter int CW     = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         go_i,
    input logic                         fault_i,
    input logic [WIDTH-1:0]             pred_req_o,
    input logic [WIDTH-1:0]             pred_taken_i,
    input logic [WIDTH-1:0]             grp_vld_o,
    input logic [WIDTH-1:0][SEQ_W-1:0]  grp_seq_o,
    input logic [CW-1:0]                grp_cnt_o,
    input logic [CNT_W-1:0]             taken_cnt_o,
    input logic [ADDR_W-1:0]            pc_out_o,
    input logic [ADDR_W-1:0]            npc_out_o
);
    // R12
    vld_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_vld_o == WIDTH'((1 << grp_cnt_o) - 1));

    // R9
    npc_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        npc_out_o == pc_out_o + ADDR_W'(4));

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_i || fault_i) |=> (grp_cnt_o == '0 && $stable(pc_out_o) && $stable(taken_cnt_o)));

    // R11
    taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (taken_cnt_o == $past(taken_cnt_o) || taken_cnt_o == $past(taken_cnt_o) + CNT_W'(1)));

    for (genvar g = 1; g < WIDTH; g++) begin : g_seq
        // R8
        seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_vld_o[g] |-> grp_seq_o[g] == grp_seq_o[g-1] + SEQ_W'(1));
    end

    for (genvar g = 0; g < WIDTH - 1; g++) begin : g_stop
        // R7
        taken_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pred_req_o[g] && pred_taken_i[g]) |=> !grp_vld_o[g+1]);
    end
endmodule

bind fgb_builder fgb_checker #(
    .ADDR_W (ADDR_W),
    .WIDTH  (WIDTH),
    .SEQ_W  (SEQ_W),
    .CNT_W  (CNT_W),
    .CW     (CW)
) i_fgb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go_i),
    .fault_i      (fault_i),
    .pred_req_o   (pred_req_o),
    .pred_taken_i (pred_taken_i),
    .grp_vld_o    (grp_vld_o),
    .grp_seq_o    (grp_seq_o),
    .grp_cnt_o    (grp_cnt_o),
    .taken_cnt_o  (taken_cnt_o),
    .pc_out_o     (pc_out_o),
    .npc_out_o    (npc_out_o)
);

// File: tb/test_fgb_builder.sv
module test_fgb_builder;
    localparam int AW = 32;
    localparam int W  = 4;
    localparam int SW = 16;
    localparam int TW = 16;
    localparam int LB = 64;
    localparam int NW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 go = 1'b0;
    logic                 fault = 1'b0;
    logic [AW-1:0]        pc = '0;
    logic [LB*8-1:0]      line = '0;
    logic [W-1:0]         preq;
    logic [W-1:0][AW-1:0] ppc;
    logic [W-1:0]         ptk = '0;
    logic [W-1:0][AW-1:0] ptg = '0;
    logic [W-1:0]         vld;
    logic [W-1:0][31:0]   gword;
    logic [W-1:0][AW-1:0] gpc;
    logic [W-1:0][AW-1:0] gnpc;
    logic [W-1:0][SW-1:0] gseq;
    logic [2:0]           gcnt;
    logic [TW-1:0]        tcnt;
    logic [AW-1:0]        pco;
    logic [AW-1:0]        npco;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    int      e_seq   = 0;
    logic [AW-1:0] e_pco = '0;
    int      e_taken = 0;

    always #5 clk = ~clk;

    fgb_builder i_fgb_builder (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_i          (go),
        .fault_i       (fault),
        .pc_i          (pc),
        .line_i        (line),
        .pred_req_o    (preq),
        .pred_pc_o     (ppc),
        .pred_taken_i  (ptk),
        .pred_target_i (ptg),
        .grp_vld_o     (vld),
        .grp_word_o    (gword),
        .grp_pc_o      (gpc),
        .grp_npc_o     (gnpc),
        .grp_seq_o     (gseq),
        .grp_cnt_o     (gcnt),
        .taken_cnt_o   (tcnt),
        .pc_out_o      (pco),
        .npc_out_o     (npco)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [5:0] opc, input int tag);
        return {opc, 26'(tag)};
    endfunction

    function automatic bit is_ctl(input logic [31:0] w);
        return (w[31:26] == 6'h1A) || (w[31:26] >= 6'h30);
    endfunction

    // Drive one request, check the predictor requests in the same cycle,
    // then check the registered group one edge later against a model.
    task automatic group(input logic [AW-1:0] p, input bit f, input bit g, input string req);
        int idx;
        int cnt;
        bit stop;
        logic [W-1:0] e_req;
        logic [W-1:0] e_vld;
        logic [31:0]  e_w   [W];
        logic [AW-1:0] e_np [W];
        int           e_sq  [W];
        idx = int'(p[5:2]);
        cnt = 0; stop = !g || f; e_req = '0; e_vld = '0;
        for (int i = 0; i < W; i++) begin
            e_w[i] = '0; e_np[i] = '0; e_sq[i] = 0;
            if (!stop && idx + i < NW) begin
                e_vld[i] = 1'b1;
                e_w[i]   = line[32*(idx+i) +: 32];
                e_np[i]  = p + AW'(4*i + 4);
                if (is_ctl(e_w[i])) begin
                    e_req[i] = 1'b1;
                    if (ptk[i]) begin
                        e_np[i] = ptg[i];
                        stop = 1'b1;
                        e_taken++;
                    end
                end
                e_sq[i] = e_seq;
                e_seq++;
                e_pco = e_np[i];
                cnt++;
            end
        end
        @(negedge clk);
        pc = p; fault = f; go = g;
        #1;
        // R6: requests only for emitted control slots, with their PCs
        chk(preq == e_req, {req, " R6 pred_req"}, 64'(preq), 64'(e_req));
        for (int i = 0; i < W; i++) begin
            if (e_req[i]) chk(ppc[i] == p + AW'(4*i), {req, " R6 pred_pc"}, 64'(ppc[i]), 64'(p + AW'(4*i)));
        end
        @(negedge clk);
        go = 1'b0; fault = 1'b0;
        // R12 / R3 / R4: count and contiguous valids
        chk(gcnt == 3'(cnt), {req, " R12 count"}, 64'(gcnt), 64'(cnt));
        chk(vld == e_vld, {req, " R12 valid"}, 64'(vld), 64'(e_vld));
        for (int i = 0; i < W; i++) begin
            if (e_vld[i]) begin
                chk(gword[i] == e_w[i], {req, " R2 word"}, 64'(gword[i]), 64'(e_w[i]));
                chk(gpc[i] == p + AW'(4*i), {req, " R2 pc"}, 64'(gpc[i]), 64'(p + AW'(4*i)));
                chk(gnpc[i] == e_np[i], {req, " R7 npc"}, 64'(gnpc[i]), 64'(e_np[i]));
                chk(gseq[i] == SW'(e_sq[i]), {req, " R8 seq"}, 64'(gseq[i]), 64'(e_sq[i]));
            end
        end
        chk(pco == e_pco, {req, " R9 pc_out"}, 64'(pco), 64'(e_pco));
        chk(npco == e_pco + 4, {req, " R9 npc_out"}, 64'(npco), 64'(e_pco + 4));
        chk(tcnt == TW'(e_taken), {req, " R11 taken count"}, 64'(tcnt), 64'(e_taken));
    endtask

    task automatic fill_alu(input int base);
        for (int k = 0; k < NW; k++) line[32*k +: 32] = mkw(6'h10, base + k);
        ptk = '0; ptg = '0;
    endtask

    task automatic t_reset();
        chk(vld == '0, "R1 valid", 64'(vld), 0);
        chk(gcnt == '0, "R1 count", 64'(gcnt), 0);
        chk(pco == '0, "R1 pc_out", 64'(pco), 0);
        chk(npco == 32'd4, "R1 npc_out", 64'(npco), 4);
        chk(tcnt == '0, "R1 taken", 64'(tcnt), 0);
    endtask

    task automatic t_width();
        fill_alu(100);
        ptk = '1; ptg = '1;           // R5: ignored on non-control words
        group(32'h1000, 1'b0, 1'b1, "R4 full width");
        group(32'h1010, 1'b0, 1'b1, "R8 second group");
    endtask

    task automatic t_line_end();
        fill_alu(200);
        group(32'h2038, 1'b0, 1'b1, "R3 two left");
        group(32'h203C, 1'b0, 1'b1, "R3 last word");
    endtask

    task automatic t_taken();
        fill_alu(300);
        line[32*1 +: 32] = mkw(6'h39, 1);
        ptk[1] = 1'b1; ptg[1] = 32'h4440;
        group(32'h3000, 1'b0, 1'b1, "R7 taken slot1");
    endtask

    task automatic t_not_taken();
        fill_alu(400);
        line[32*4 +: 32] = mkw(6'h30, 4);
        ptg[0] = 32'h9990;
        group(32'h5010, 1'b0, 1'b1, "R7 not taken");
    endtask

    task automatic t_jump();
        fill_alu(500);
        ptk[0] = 1'b1; ptg[0] = 32'hDEAD0000;
        line[32*2 +: 32] = mkw(6'h1A, 2);
        ptk[2] = 1'b1; ptg[2] = 32'h0000_7700;
        group(32'h6000, 1'b0, 1'b1, "R6 jump opcode");
    endtask

    task automatic t_quiet();
        fill_alu(600);
        line[0 +: 32] = mkw(6'h3F, 0);
        ptk[0] = 1'b1; ptg[0] = 32'h1234_0000;
        group(32'h7000, 1'b1, 1'b1, "R10 fault");
        group(32'h7000, 1'b0, 1'b0, "R10 idle");
        ptk = '0;
        group(32'h7000, 1'b0, 1'b1, "R10 after quiet");
    endtask

    task automatic t_endian();
        for (int b = 0; b < LB; b++) line[8*b +: 8] = 8'(b);
        ptk = '0;
        group(32'h8014, 1'b0, 1'b1, "R2 byte order");
        chk(gword[0] == 32'h17161514, "R2 little-endian word", 64'(gword[0]), 64'h17161514);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_width();
        t_line_end();
        t_taken();
        t_not_taken();
        t_jump();
        t_quiet();
        t_endian();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule